// File: doc/BRIEF.md
# Priority-Masked Interrupt Entry Sequencer

This block sits beside a processor core and decides which interrupt request is taken. It runs the hardware part of entering and leaving a handler. Several request sources each present a 5-bit priority and an 8-bit vector. A separate non-maskable request line bypasses the mask. The block holds a process-control word (`pc_out`) whose low five bits are the current mask level and whose bit 31 is the "interrupted" state bit. It also holds the frame pointer (`fp_out`).

When a request is taken, the block does the following:
- It reserves a 16-byte record on the interrupt stack.
- It writes the old process-control word and the arithmetic-control word (`ac_live`) into that record, one word per cycle, through its stack write port.
- It raises the mask to the taken priority.
- It presents the handler address, looked up from an internal table indexed by vector. Software loads that table.

A return request reverses the entry. The block reads the two saved words back, steps the frame pointer down by 16 and restores the control words. It also reports whether the restored state is outside any interrupt, which marks the exit from the outermost handler.

Top module: `irq_entry_seq`

## Requirements
- R1: After synchronous reset, `busy` is 0, `pc_out` is 0, `fp_out` equals the stack base parameter, and `entry_done`, `ret_done`, `outer_exit` and `stk_we` are 0.
- R2: A maskable request is taken only if its priority is strictly greater than the mask in `pc_out[4:0]`. A request at or below the mask leaves `busy` low and `pc_out` unchanged, so priority 0 is never taken.
- R3: Among eligible maskable requests, the highest priority wins, and a priority tie goes to the lower vector number.
- R4: `nmi_req` is taken whatever the mask, even at 31, and wins over any maskable request. It sets the mask to 31 and the vector to the NMI vector parameter.
- R5: On taking a request at clock edge k, the following hold after edge k: `busy` is 1, `pc_out` equals {bit31=1, bits[4:0]=priority, other bits 0}, and `act_vec` equals the vector. After edge k+2, `busy` is 0, `entry_done` is high for one cycle, and `handler_addr` equals the table entry for that vector.
- R6: If `pc_out[31]` is 0 when a request is taken, the frame pointer becomes stack base + 16. If it is 1 (a nested entry), the frame pointer becomes its old value + 16.
- R7: The record is written during the cycles after edges k and k+1, with `stk_we` high in both. The first write puts the old `pc_out` at new frame − 16, and the second puts `ac_live` (sampled at edge k) at new frame − 12. Offsets −8 and −4 are never written.
- R8: While `busy` is high, no new request is taken. A request held through the entry is taken on the first cycle after `busy` falls.
- R9: A write on the table port (`tbl_we`, `tbl_addr`, `tbl_wdata`) replaces the handler address returned for that vector on later entries.
- R10: `ret_req` with `pc_out[31]` at 1, accepted at edge r, gives `ret_done` for one cycle after edge r+3. At that point `pc_out` and `ac_restore` hold the words saved in the current record, and `fp_out` has dropped by 16. `outer_exit` is high with it exactly when the restored bit 31 is 0. With `pc_out[31]` at 0, `ret_req` is ignored.
- R11: When a request can be taken in the same cycle as `ret_req`, the request is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pend | input | NUM_SRC | Pending flag per maskable source |
| req_prio | input | NUM_SRC*5 | Priority per source, source i in bits [5i+4:5i] |
| req_vec | input | NUM_SRC*8 | Vector per source, source i in bits [8i+7:8i] |
| nmi_req | input | 1 | Non-maskable request |
| ret_req | input | 1 | Return-from-handler request |
| ac_live | input | 32 | Current arithmetic-control word to save |
| tbl_we | input | 1 | Handler table write enable |
| tbl_addr | input | 8 | Handler table write index (vector) |
| tbl_wdata | input | 32 | Handler address to store |
| busy | output | 1 | Entry or return sequence in progress |
| fp_out | output | 32 | Frame pointer (byte address) |
| pc_out | output | 32 | Process-control word: bit 31 state, bits 4:0 mask |
| act_vec | output | 8 | Vector of the last taken request |
| handler_addr | output | 32 | Handler address, valid with entry_done |
| entry_done | output | 1 | One-cycle pulse at the end of entry |
| ret_done | output | 1 | One-cycle pulse at the end of return |
| outer_exit | output | 1 | With ret_done: outermost level exited |
| ac_restore | output | 32 | Restored arithmetic-control word |
| stk_we | output | 1 | Stack word write strobe |
| stk_addr | output | 32 | Stack write byte address |
| stk_wdata | output | 32 | Stack write data |

## Verification
A wrong frame pointer or state bit would show in the entry cycle. `fp_out` and the stack write addresses would be visible one clock after the request is taken. The damage then carries forward, because a later return reads the wrong record: `pc_out`, `ac_restore` and `outer_exit` come out wrong three cycles after `ret_req`. Arbitration and masking faults show one cycle after the request as a wrong mask in `pc_out` or in `act_vec`, or as a `busy` that should not have risen. Nesting is driven two and three levels deep, so that a state bit saved wrongly reveals itself only at the outermost return.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int PRIO_W    = 5;
  localparam int VEC_W     = 8;
  localparam int WORD_W    = 32;
  localparam int STATE_BIT = 31;
  localparam logic [PRIO_W-1:0] TOP_PRIO = '1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE_PC,
    ST_SAVE_AC,
    ST_RD_PC,
    ST_RD_AC,
    ST_RESTORE
  } seq_state_t;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter import irq_seq_pkg::*; #(
  parameter int NUM_SRC = 4
) (
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic [NUM_SRC*VEC_W-1:0]  vec_flat,
  input  logic [PRIO_W-1:0]         mask,
  output logic                      hit,
  output logic [PRIO_W-1:0]         win_prio,
  output logic [VEC_W-1:0]          win_vec
);
  logic [PRIO_W-1:0] prio_a [NUM_SRC];
  logic [VEC_W-1:0]  vec_a  [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign prio_a[g] = prio_flat[g*PRIO_W +: PRIO_W];
    assign vec_a[g]  = vec_flat[g*VEC_W +: VEC_W];
  end

  always_comb begin
    hit      = 1'b0;
    win_prio = '0;
    win_vec  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && (prio_a[i] > mask)) begin
        if (!hit || (prio_a[i] > win_prio) ||
            ((prio_a[i] == win_prio) && (vec_a[i] < win_vec))) begin
          hit      = 1'b1;
          win_prio = prio_a[i];
          win_vec  = vec_a[i];
        end
      end
    end
  end
endmodule

// File: rtl/handler_table.sv
module handler_table import irq_seq_pkg::*; (
  input  logic              clk,
  input  logic              we,
  input  logic [VEC_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [VEC_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << VEC_W;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/stack_ram.sv
module stack_ram import irq_seq_pkg::*; #(
  parameter int WORDS = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] idx,
  input  logic [WORD_W-1:0]        wdata,
  output logic [WORD_W-1:0]        rdata
);
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    rdata <= mem[idx];
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq import irq_seq_pkg::*; #(
  parameter int                NUM_SRC   = 4,
  parameter int                STK_WORDS = 64,
  parameter logic [WORD_W-1:0] ISTK_BASE = 32'h0000_1000,
  parameter logic [VEC_W-1:0]  NMI_VEC   = 8'hFF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        req_pend,
  input  logic [NUM_SRC*PRIO_W-1:0] req_prio,
  input  logic [NUM_SRC*VEC_W-1:0]  req_vec,
  input  logic                      nmi_req,
  input  logic                      ret_req,
  input  logic [WORD_W-1:0]         ac_live,
  input  logic                      tbl_we,
  input  logic [VEC_W-1:0]          tbl_addr,
  input  logic [WORD_W-1:0]         tbl_wdata,
  output logic                      busy,
  output logic [WORD_W-1:0]         fp_out,
  output logic [WORD_W-1:0]         pc_out,
  output logic [VEC_W-1:0]          act_vec,
  output logic [WORD_W-1:0]         handler_addr,
  output logic                      entry_done,
  output logic                      ret_done,
  output logic                      outer_exit,
  output logic [WORD_W-1:0]         ac_restore,
  output logic                      stk_we,
  output logic [WORD_W-1:0]         stk_addr,
  output logic [WORD_W-1:0]         stk_wdata
);
  localparam int IDX_W = $clog2(STK_WORDS);
  localparam logic [WORD_W-1:0] REC_BYTES = 32'd16;

  seq_state_t        st_q;
  logic [WORD_W-1:0] fp_q, pc_q, ac_save_q, pc_tmp_q, hnd_q, ac_rest_q;
  logic [WORD_W-1:0] wr_addr_q, wr_data_q;
  logic              wr_en_q, busy_q, entry_done_q, ret_done_q, outer_q;
  logic [VEC_W-1:0]  vec_q;

  logic              arb_hit;
  logic [PRIO_W-1:0] arb_prio, g_prio;
  logic [VEC_W-1:0]  arb_vec, g_vec;
  logic              take_irq, take_ret, nested;
  logic [WORD_W-1:0] rec_base, rd_addr, ram_addr;
  logic [WORD_W-1:0] tbl_rdata, stk_rdata;

  irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend(req_pend), .prio_flat(req_prio), .vec_flat(req_vec),
    .mask(pc_q[PRIO_W-1:0]), .hit(arb_hit), .win_prio(arb_prio), .win_vec(arb_vec)
  );

  handler_table u_tbl (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .raddr(vec_q), .rdata(tbl_rdata)
  );

  always_comb begin
    nested   = pc_q[STATE_BIT];
    g_prio   = nmi_req ? TOP_PRIO : arb_prio;
    g_vec    = nmi_req ? NMI_VEC : arb_vec;
    take_irq = (st_q == ST_IDLE) && (nmi_req || arb_hit);
    take_ret = (st_q == ST_IDLE) && !take_irq && ret_req && nested;
    rec_base = nested ? fp_q : ISTK_BASE;
    rd_addr  = (st_q == ST_RD_PC) ? fp_q - REC_BYTES : fp_q - 32'd12;
    ram_addr = wr_en_q ? wr_addr_q : rd_addr;
  end

  stack_ram #(.WORDS(STK_WORDS)) u_stk (
    .clk(clk), .we(wr_en_q), .idx(ram_addr[IDX_W+1:2]),
    .wdata(wr_data_q), .rdata(stk_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      fp_q         <= ISTK_BASE;
      pc_q         <= '0;
      ac_save_q    <= '0;
      pc_tmp_q     <= '0;
      hnd_q        <= '0;
      ac_rest_q    <= '0;
      wr_addr_q    <= '0;
      wr_data_q    <= '0;
      wr_en_q      <= 1'b0;
      busy_q       <= 1'b0;
      entry_done_q <= 1'b0;
      ret_done_q   <= 1'b0;
      outer_q      <= 1'b0;
      vec_q        <= '0;
    end else begin
      entry_done_q <= 1'b0;
      ret_done_q   <= 1'b0;
      outer_q      <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (take_irq) begin
            st_q      <= ST_SAVE_PC;
            busy_q    <= 1'b1;
            vec_q     <= g_vec;
            fp_q      <= rec_base + REC_BYTES;
            pc_q      <= {1'b1, {(WORD_W-1-PRIO_W){1'b0}}, g_prio};
            ac_save_q <= ac_live;
            wr_en_q   <= 1'b1;
            wr_addr_q <= rec_base;
            wr_data_q <= pc_q;
          end else if (take_ret) begin
            st_q   <= ST_RD_PC;
            busy_q <= 1'b1;
          end
        end
        ST_SAVE_PC: begin
          wr_addr_q <= wr_addr_q + 32'd4;
          wr_data_q <= ac_save_q;
          st_q      <= ST_SAVE_AC;
        end
        ST_SAVE_AC: begin
          wr_en_q      <= 1'b0;
          busy_q       <= 1'b0;
          entry_done_q <= 1'b1;
          hnd_q        <= tbl_rdata;
          st_q         <= ST_IDLE;
        end
        ST_RD_PC: st_q <= ST_RD_AC;
        ST_RD_AC: begin
          pc_tmp_q <= stk_rdata;
          st_q     <= ST_RESTORE;
        end
        ST_RESTORE: begin
          pc_q       <= pc_tmp_q;
          ac_rest_q  <= stk_rdata;
          fp_q       <= fp_q - REC_BYTES;
          ret_done_q <= 1'b1;
          outer_q    <= !pc_tmp_q[STATE_BIT];
          busy_q     <= 1'b0;
          st_q       <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy         = busy_q;
  assign fp_out       = fp_q;
  assign pc_out       = pc_q;
  assign act_vec      = vec_q;
  assign handler_addr = hnd_q;
  assign entry_done   = entry_done_q;
  assign ret_done     = ret_done_q;
  assign outer_exit   = outer_q;
  assign ac_restore   = ac_rest_q;
  assign stk_we       = wr_en_q;
  assign stk_addr     = wr_addr_q;
  assign stk_wdata    = wr_data_q;

  AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !nmi_req && !arb_hit && !ret_req) |=> !busy_q); // R2
  AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && nmi_req) |=> busy_q && pc_q[PRIO_W-1:0] == TOP_PRIO && vec_q == NMI_VEC); // R4
  AST_ENTRY_MASK: assert property (@(posedge clk) disable iff (rst)
    take_irq |=> pc_q[STATE_BIT] && pc_q[PRIO_W-1:0] == $past(g_prio)); // R5
  AST_ENTRY_FP: assert property (@(posedge clk) disable iff (rst)
    take_irq |=> fp_q == ($past(pc_q[STATE_BIT]) ? $past(fp_q) + REC_BYTES : ISTK_BASE + REC_BYTES)); // R6
  AST_AC_SLOT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SAVE_AC) |-> wr_en_q && wr_addr_q == fp_q - 32'd12); // R7
  AST_BUSY_SEQ: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |-> busy_q); // R8
  AST_RET_FP: assert property (@(posedge clk) disable iff (rst)
    ret_done_q |-> fp_q == $past(fp_q) - REC_BYTES); // R10
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [7:0]  NMIV = 8'hFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  req_pend = '0;
  logic [19:0] req_prio = '0;
  logic [31:0] req_vec = '0;
  logic        nmi_req = 1'b0, ret_req = 1'b0, tbl_we = 1'b0;
  logic [31:0] ac_live = '0, tbl_wdata = '0;
  logic [7:0]  tbl_addr = '0;
  logic        busy, entry_done, ret_done, outer_exit, stk_we;
  logic [31:0] fp_out, pc_out, handler_addr, ac_restore, stk_addr, stk_wdata;
  logic [7:0]  act_vec;

  always #2 clk = ~clk;

  irq_entry_seq u_dut (
    .clk(clk), .rst(rst), .req_pend(req_pend), .req_prio(req_prio), .req_vec(req_vec),
    .nmi_req(nmi_req), .ret_req(ret_req), .ac_live(ac_live), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .busy(busy), .fp_out(fp_out),
    .pc_out(pc_out), .act_vec(act_vec), .handler_addr(handler_addr),
    .entry_done(entry_done), .ret_done(ret_done), .outer_exit(outer_exit),
    .ac_restore(ac_restore), .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata)
  );

  int checks = 0, failures = 0, ac_cnt = 0, depth = 0;
  bit finished = 1'b0;
  logic [31:0] m_pc = '0, m_fp = BASE;
  logic [31:0] sv_pc [8];
  logic [31:0] sv_ac [8];
  logic [31:0] exp_tbl [256];

  // row: mask-setup priority, request priority, expected accept
  localparam logic [10:0] ROWS [8] = '{
    {5'd0, 5'd1, 1'b1}, {5'd0, 5'd31, 1'b1}, {5'd0, 5'd0, 1'b0}, {5'd4, 5'd4, 1'b0},
    {5'd4, 5'd3, 1'b0}, {5'd4, 5'd5, 1'b1}, {5'd30, 5'd31, 1'b1}, {5'd31, 5'd31, 1'b0}};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pcw(input logic [4:0] p);
    return {1'b1, 26'b0, p};
  endfunction

  task automatic fire(input logic [3:0] pend, input logic [19:0] pr, input logic [31:0] vc,
                      input bit nmi, input bit with_ret, input bit exp_acc,
                      input logic [4:0] ep, input logic [7:0] ev);
    logic [31:0] acv, base;
    acv = 32'hAC00_0000 + ac_cnt;
    ac_cnt++;
    @(negedge clk);
    req_pend = pend; req_prio = pr; req_vec = vc; nmi_req = nmi; ret_req = with_ret; ac_live = acv;
    @(negedge clk);
    req_pend = '0; nmi_req = 1'b0; ret_req = 1'b0;
    if (exp_acc) begin
      base = m_pc[31] ? m_fp : BASE;
      chk(busy == 1'b1, "R5 busy after accept", {31'b0, busy}, 32'd1);
      chk(pc_out == pcw(ep), "R5 pc after accept", pc_out, pcw(ep));
      chk(act_vec == ev, "R3 winning vector", {24'b0, act_vec}, {24'b0, ev});
      chk(fp_out == base + 32'd16, "R6 frame pointer", fp_out, base + 32'd16);
      chk(stk_we && stk_addr == base && stk_wdata == m_pc, "R7 saved pc word", stk_addr, base);
      @(negedge clk);
      chk(stk_we && stk_addr == base + 32'd4 && stk_wdata == acv, "R7 saved ac word", stk_wdata, acv);
      @(negedge clk);
      chk(entry_done && !busy && !stk_we, "R5 entry done", {31'b0, entry_done}, 32'd1);
      chk(handler_addr == exp_tbl[ev], "R9 handler address", handler_addr, exp_tbl[ev]);
      sv_pc[depth] = m_pc; sv_ac[depth] = acv; depth++;
      m_pc = pcw(ep); m_fp = base + 32'd16;
    end else begin
      chk(!busy, "R2 masked request ignored", {31'b0, busy}, 32'd0);
      chk(pc_out == m_pc, "R2 pc unchanged", pc_out, m_pc);
    end
  endtask

  task automatic do_ret(input bit exp_done);
    @(negedge clk); ret_req = 1'b1;
    @(negedge clk); ret_req = 1'b0;
    if (exp_done) begin
      repeat (2) @(negedge clk);
      chk(busy && !ret_done, "R10 return in progress", {31'b0, ret_done}, 32'd0);
      @(negedge clk);
      chk(ret_done && !busy, "R10 ret_done pulse", {31'b0, ret_done}, 32'd1);
      chk(pc_out == sv_pc[depth-1], "R10 restored pc", pc_out, sv_pc[depth-1]);
      chk(ac_restore == sv_ac[depth-1], "R10 restored ac", ac_restore, sv_ac[depth-1]);
      chk(fp_out == m_fp - 32'd16, "R10 frame pointer back", fp_out, m_fp - 32'd16);
      chk(outer_exit == (depth == 1), "R10 outermost exit flag", {31'b0, outer_exit}, {31'b0, depth == 1});
      m_pc = sv_pc[depth-1]; m_fp = m_fp - 32'd16; depth--;
    end else begin
      repeat (4) begin
        chk(!busy && !ret_done, "R10 return ignored outside handler", {31'b0, ret_done}, 32'd0);
        @(negedge clk);
      end
      chk(fp_out == m_fp && pc_out == m_pc, "R10 state kept", fp_out, m_fp);
    end
  endtask

  task automatic unwind();
    while (depth > 0) do_ret(1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(!busy && pc_out == 0 && fp_out == BASE, "R1 reset state", fp_out, BASE);
    chk(!entry_done && !ret_done && !outer_exit && !stk_we, "R1 reset pulses low", {31'b0, stk_we}, 32'd0);
    // R9 table load
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = v[7:0]; tbl_wdata = 32'h4000_0000 | (v << 4);
      exp_tbl[v] = 32'h4000_0000 | (v << 4);
    end
    @(negedge clk); tbl_we = 1'b0;

    // table walk: R2 R5 R6 R7 R10
    for (int i = 0; i < 8; i++) begin
      logic [4:0] mset, preq;
      logic [7:0] vreq;
      mset = ROWS[i][10:6]; preq = ROWS[i][5:1];
      vreq = 8'h20 + 8'(i);
      if (mset != 0) fire(4'b0001, {15'b0, mset}, {24'b0, 8'h10 + 8'(i)}, 1'b0, 1'b0, 1'b1, mset, 8'h10 + 8'(i));
      fire(4'b0001, {15'b0, preq}, {24'b0, vreq}, 1'b0, 1'b0, ROWS[i][0], preq, vreq);
      unwind();
    end

    // R3 highest priority wins, tie goes to lower vector
    fire(4'b1111, {5'd2, 5'd7, 5'd7, 5'd3}, {8'd5, 8'd12, 8'd40, 8'd9}, 1'b0, 1'b0, 1'b1, 5'd7, 8'd12);
    unwind();
    fire(4'b1010, {5'd6, 5'd0, 5'd6, 5'd0}, {8'd20, 8'd0, 8'd50, 8'd0}, 1'b0, 1'b0, 1'b1, 5'd6, 8'd20);
    unwind();

    // R4 NMI at mask 31, beating a pending maskable request
    fire(4'b0001, {15'b0, 5'd31}, {24'b0, 8'd3}, 1'b0, 1'b0, 1'b1, 5'd31, 8'd3);
    fire(4'b0001, {15'b0, 5'd31}, {24'b0, 8'd4}, 1'b1, 1'b0, 1'b1, 5'd31, NMIV);
    fire(4'b0000, '0, '0, 1'b1, 1'b0, 1'b1, 5'd31, NMIV);
    chk(depth == 3 && fp_out == BASE + 32'd48, "R6 three-deep frame", fp_out, BASE + 32'd48);
    unwind();

    // R8 request held through busy is taken only after entry completes
    @(negedge clk);
    ac_live = 32'h0BAD_0001;
    req_pend = 4'b0001; req_prio = {15'b0, 5'd5}; req_vec = {24'b0, 8'd1};
    @(negedge clk);
    req_pend = 4'b0010; req_prio = {10'b0, 5'd9, 5'd0}; req_vec = {16'b0, 8'd2, 8'd0};
    chk(busy && pc_out[4:0] == 5'd5, "R8 first entry", pc_out, pcw(5'd5));
    @(negedge clk);
    chk(pc_out[4:0] == 5'd5, "R8 blocked while busy", pc_out, pcw(5'd5));
    @(negedge clk);
    chk(entry_done && pc_out[4:0] == 5'd5, "R8 still blocked at done", pc_out, pcw(5'd5));
    @(negedge clk);
    req_pend = '0;
    chk(busy && pc_out == pcw(5'd9) && act_vec == 8'd2, "R8 taken after busy", pc_out, pcw(5'd9));
    repeat (2) @(negedge clk);
    sv_pc[0] = 32'd0; sv_ac[0] = 32'h0BAD_0001;
    sv_pc[1] = pcw(5'd5); sv_ac[1] = 32'h0BAD_0001;
    depth = 2; m_pc = pcw(5'd9); m_fp = BASE + 32'd32;
    unwind();

    // R10 return with no active handler
    do_ret(1'b0);

    // R11 accept beats simultaneous return
    fire(4'b0001, {15'b0, 5'd3}, {24'b0, 8'd7}, 1'b0, 1'b0, 1'b1, 5'd3, 8'd7);
    fire(4'b0001, {15'b0, 5'd8}, {24'b0, 8'd8}, 1'b0, 1'b1, 1'b1, 5'd8, 8'd8);
    chk(depth == 2 && pc_out == pcw(5'd8), "R11 accept over return", pc_out, pcw(5'd8));
    unwind();

    // R9 table rewrite
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 8'h33; tbl_wdata = 32'hDEAD_BEE0; exp_tbl[8'h33] = 32'hDEAD_BEE0;
    @(negedge clk); tbl_we = 1'b0;
    fire(4'b0100, {5'd0, 5'd12, 10'b0}, {8'd0, 8'h33, 16'b0}, 1'b0, 1'b0, 1'b1, 5'd12, 8'h33);
    unwind();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule